// File: doc/BRIEF.md
# CPU Interrupt Priority Gate

This block keeps the processor's global interrupt enable bit and its current priority level. It decides whether an incoming prioritised interrupt request is taken. Each request arrives as a valid strobe together with a priority level and an urgent flag. The urgent flag marks a hardware trap or an external non-maskable interrupt. An ordinary (maskable) request is taken only while interrupts are enabled and only if its priority beats the running level. An urgent request is always taken.

When a request is taken, the block raises an acknowledge output in the same cycle. On the following clock edge it loads the running level with the priority of the accepted request. Software can write the enable bit and the level directly, for example to hold off low-priority sources. A restore port reloads both values when returning from an interrupt.

The asynchronous active-low reset is released synchronously inside the block.

Top module: `irq_prio_gate`

## Requirements
- R1: After reset, `cur_enable` is 0, `cur_level` is 0 and `ack` is 0.
- R2: A maskable request (`req_valid`=1, `req_urgent`=0) gives `ack`=1 in the same cycle exactly when `cur_enable`=1 and `req_level` is strictly greater than `cur_level` (unsigned compare).
- R3: While `cur_enable`=0, no maskable request is acknowledged.
- R4: While `cur_level` is 15 (all ones), no maskable request is acknowledged, even with `cur_enable`=1.
- R5: An urgent request (`req_valid`=1, `req_urgent`=1) is acknowledged whatever `cur_enable` and `cur_level` are.
- R6: In the cycle after `ack`=1, `cur_level` equals the `req_level` of the accepted request, and `cur_enable` is unchanged.
- R7: A software write (`sw_wr`=1) loads `sw_enable` and `sw_level` into `cur_enable` and `cur_level`, visible in the next cycle. This applies only when neither an acknowledge nor a restore happens in the same cycle.
- R8: Update priority within a cycle is fixed: acknowledge entry first, then restore (`rti_load`), then software write. A restore loads `rti_enable` and `rti_level` in one cycle.
- R9: `ack` is never 1 while `req_valid` is 0.
- R10: In a cycle with no acknowledge, no restore and no software write, `cur_enable` and `cur_level` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An interrupt request is present this cycle |
| req_level | input | 4 | Priority of the request |
| req_urgent | input | 1 | Request is a trap or non-maskable interrupt |
| sw_wr | input | 1 | Software write strobe |
| sw_enable | input | 1 | Enable value written by software |
| sw_level | input | 4 | Level value written by software |
| rti_load | input | 1 | Restore strobe on interrupt return |
| rti_enable | input | 1 | Enable value to restore |
| rti_level | input | 4 | Level value to restore |
| ack | output | 1 | Request accepted this cycle |
| cur_enable | output | 1 | Global interrupt enable |
| cur_level | output | 4 | Current processor priority level |

## Verification
On every cycle, the assertions check how the acknowledge relates to the enable bit, the level compare, the urgent bypass and the strobe. On the following cycle they check the level loaded by entry, restore or write, and that the state holds when nothing happens.

Only the bench's scenarios can show the following:
- the reset values;
- that a full sweep of enable, running level, request level and urgency produces exactly the expected acknowledge pattern;
- how the update sources rank when they collide in one cycle.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned IRQ_LVL_W = 4;

  // Source of the status update taken at the next edge
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_ENTRY   = 2'd1,
    UPD_RESTORE = 2'd2,
    UPD_SWWRITE = 2'd3
  } upd_src_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             req_urgent,
  input  logic             cur_enable,
  input  logic [LVL_W-1:0] cur_level,
  output logic             accept
);
  logic maskable_ok;

  // Strict compare: a request at the top level can never exceed a top-level CPU
  always_comb begin
    maskable_ok = cur_enable && (req_level > cur_level);
    accept      = req_valid && (req_urgent || maskable_ok);
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_gate_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry,
  input  logic [LVL_W-1:0] entry_level,
  input  logic             rti_load,
  input  logic             rti_enable,
  input  logic [LVL_W-1:0] rti_level,
  input  logic             sw_wr,
  input  logic             sw_enable,
  input  logic [LVL_W-1:0] sw_level,
  output logic             cur_enable,
  output logic [LVL_W-1:0] cur_level
);
  upd_src_e         src;
  logic             load_en;
  logic             enable_d, enable_q;
  logic [LVL_W-1:0] level_d, level_q;

  // Fixed ranking: hardware entry, then restore, then software write
  always_comb begin
    if (entry)         src = UPD_ENTRY;
    else if (rti_load) src = UPD_RESTORE;
    else if (sw_wr)    src = UPD_SWWRITE;
    else               src = UPD_NONE;
  end

  always_comb begin
    enable_d = enable_q;
    level_d  = level_q;
    unique case (src)
      UPD_ENTRY: begin
        level_d = entry_level;
      end
      UPD_RESTORE: begin
        enable_d = rti_enable;
        level_d  = rti_level;
      end
      UPD_SWWRITE: begin
        enable_d = sw_enable;
        level_d  = sw_level;
      end
      default: ;
    endcase
  end

  assign load_en = (src != UPD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      level_q  <= '0;
    end else if (load_en) begin
      enable_q <= enable_d;
      level_q  <= level_d;
    end
  end

  assign cur_enable = enable_q;
  assign cur_level  = level_q;
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned LVL_W = IRQ_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             req_urgent,
  input  logic             sw_wr,
  input  logic             sw_enable,
  input  logic [LVL_W-1:0] sw_level,
  input  logic             rti_load,
  input  logic             rti_enable,
  input  logic [LVL_W-1:0] rti_level,
  output logic             ack,
  output logic             cur_enable,
  output logic [LVL_W-1:0] cur_level
);
  logic rst_n_sync;
  logic accept;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_accept #(.LVL_W(LVL_W)) u_accept (
    .req_valid  (req_valid),
    .req_level  (req_level),
    .req_urgent (req_urgent),
    .cur_enable (cur_enable),
    .cur_level  (cur_level),
    .accept     (accept)
  );

  // No acknowledge while the internal reset is still held
  assign ack = accept && rst_n_sync;

  irq_status_reg #(.LVL_W(LVL_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .entry       (ack),
    .entry_level (req_level),
    .rti_load    (rti_load),
    .rti_enable  (rti_enable),
    .rti_level   (rti_level),
    .sw_wr       (sw_wr),
    .sw_enable   (sw_enable),
    .sw_level    (sw_level),
    .cur_enable  (cur_enable),
    .cur_level   (cur_level)
  );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LVL_W-1:0] req_level,
  input logic             req_urgent,
  input logic             sw_wr,
  input logic             sw_enable,
  input logic [LVL_W-1:0] sw_level,
  input logic             rti_load,
  input logic             rti_enable,
  input logic [LVL_W-1:0] rti_level,
  input logic             ack,
  input logic             cur_enable,
  input logic [LVL_W-1:0] cur_level
);
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !ack); // R9
  AST_MASK_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_urgent) |-> (ack == (cur_enable && (req_level > cur_level)))); // R2
  AST_DISABLED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_urgent && !cur_enable) |-> !ack); // R3
  AST_TOP_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_urgent && cur_level == LVL_TOP) |-> !ack); // R4
  AST_URGENT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_urgent) |-> ack); // R5
  AST_ENTRY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (cur_level == $past(req_level)) && (cur_enable == $past(cur_enable))); // R6
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && rti_load) |=> (cur_level == $past(rti_level)) && (cur_enable == $past(rti_enable))); // R8
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !rti_load && sw_wr) |=> (cur_level == $past(sw_level)) && (cur_enable == $past(sw_enable))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !rti_load && !sw_wr) |=> $stable(cur_level) && $stable(cur_enable)); // R10
endmodule

bind irq_prio_gate irq_gate_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .req_valid  (req_valid),
  .req_level  (req_level),
  .req_urgent (req_urgent),
  .sw_wr      (sw_wr),
  .sw_enable  (sw_enable),
  .sw_level   (sw_level),
  .rti_load   (rti_load),
  .rti_enable (rti_enable),
  .rti_level  (rti_level),
  .ack        (ack),
  .cur_enable (cur_enable),
  .cur_level  (cur_level)
);

// File: tb/irq_prio_gate_tb.sv
module irq_prio_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_urgent = 1'b0;
  logic [3:0] req_level = '0;
  logic       sw_wr = 1'b0, sw_enable = 1'b0;
  logic [3:0] sw_level = '0;
  logic       rti_load = 1'b0, rti_enable = 1'b0;
  logic [3:0] rti_level = '0;
  logic       ack, cur_enable;
  logic [3:0] cur_level;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_level(req_level), .req_urgent(req_urgent),
    .sw_wr(sw_wr), .sw_enable(sw_enable), .sw_level(sw_level),
    .rti_load(rti_load), .rti_enable(rti_enable), .rti_level(rti_level),
    .ack(ack), .cur_enable(cur_enable), .cur_level(cur_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs change just after the falling edge; outputs are sampled 1 ns later
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic sw_set(input bit en, input int lvl);
    sw_wr = 1'b1; sw_enable = en; sw_level = 4'(lvl);
    step();
    sw_wr = 1'b0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    chk(cur_enable == 1'b0, "R1 enable", cur_enable, 0);
    chk(cur_level == 4'd0, "R1 level", cur_level, 0);
    chk(ack == 1'b0, "R1 ack", ack, 0);

    // R9: no request, no acknowledge
    req_urgent = 1'b1; req_level = 4'd9; #1;
    chk(ack == 1'b0, "R9 idle", ack, 0);
    req_urgent = 1'b0;

    // Exhaustive sweep over enable, running level, request level and urgency
    for (int en = 0; en < 2; en++) begin
      for (int cl = 0; cl < 16; cl++) begin
        for (int rl = 0; rl < 16; rl++) begin
          for (int ur = 0; ur < 2; ur++) begin
            bit exp_ack;
            sw_set(en[0], cl);
            chk(cur_enable == en[0] && cur_level == 4'(cl), "R7 write",
                {cur_enable, cur_level}, {en[0], 4'(cl)});
            req_valid = 1'b1; req_level = 4'(rl); req_urgent = ur[0];
            #1;
            exp_ack = (ur == 1) || (en == 1 && rl > cl);
            if (ur == 1)        chk(ack == 1'b1, "R5 urgent", ack, 1);
            else if (en == 0)   chk(ack == 1'b0, "R3 disabled", ack, 0);
            else if (cl == 15)  chk(ack == 1'b0, "R4 top level", ack, 0);
            else                chk(ack == exp_ack, "R2 compare", ack, exp_ack);
            step();
            req_valid = 1'b0; req_urgent = 1'b0;
            if (exp_ack) begin
              chk(cur_level == 4'(rl), "R6 level", cur_level, rl);
              chk(cur_enable == en[0], "R6 enable kept", cur_enable, en);
            end else begin
              chk(cur_level == 4'(cl) && cur_enable == en[0], "R10 hold",
                  {cur_enable, cur_level}, {en[0], 4'(cl)});
            end
          end
        end
      end
    end

    // R8: entry beats restore and write in the same cycle
    sw_set(1'b1, 2);
    req_valid = 1'b1; req_level = 4'd5;
    rti_load = 1'b1; rti_enable = 1'b0; rti_level = 4'd7;
    sw_wr = 1'b1; sw_enable = 1'b1; sw_level = 4'd9;
    #1;
    chk(ack == 1'b1, "R8 entry ack", ack, 1);
    step();
    req_valid = 1'b0; rti_load = 1'b0; sw_wr = 1'b0;
    chk(cur_level == 4'd5 && cur_enable == 1'b1, "R8 entry wins",
        {cur_enable, cur_level}, {1'b1, 4'd5});

    // R8: restore beats write
    rti_load = 1'b1; rti_enable = 1'b0; rti_level = 4'd3;
    sw_wr = 1'b1; sw_enable = 1'b1; sw_level = 4'd9;
    step();
    rti_load = 1'b0; sw_wr = 1'b0;
    chk(cur_level == 4'd3 && cur_enable == 1'b0, "R8 restore wins",
        {cur_enable, cur_level}, {1'b0, 4'd3});

    // R8: restore alone reloads both fields
    rti_load = 1'b1; rti_enable = 1'b1; rti_level = 4'd12;
    step();
    rti_load = 1'b0;
    chk(cur_level == 4'd12 && cur_enable == 1'b1, "R8 restore",
        {cur_enable, cur_level}, {1'b1, 4'd12});

    // R10: idle cycles keep the state
    step(); step(); step();
    chk(cur_level == 4'd12 && cur_enable == 1'b1, "R10 idle",
        {cur_enable, cur_level}, {1'b1, 4'd12});

    // R1: reset again restores the initial state
    rst_n = 1'b0; #1;
    chk(cur_enable == 1'b0 && cur_level == 4'd0, "R1 re-reset",
        {cur_enable, cur_level}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule